// File: doc/BRIEF.md
# Vector Operand Swizzle Router

This block sits between the register file and the arithmetic datapath of a four-lane vector shader unit. For each issued instruction it turns the raw source and destination fields into concrete register-file reads and write controls. It adds an address-register offset to the first source index when asked to. It classifies each effective source index into a bank (input, temporary or float uniform) and returns the fetched vectors reordered lane by lane. Each routed vector can be sign-flipped as a whole. The block also decides which bank, register and lanes the result will be written to.

Lane reordering, sign flips and the write-lane mask are not carried in the instruction. They live in a 16-entry pattern table selected by a 4-bit descriptor id, and software fills that table one entry per write. Read indices are produced combinationally in the issue cycle. The register file answers in the same cycle, and the routed operands and write controls appear registered one cycle later with a valid flag.

Top module: `vec_operand_router`

## Requirements
- R1: A pattern entry holds lane selectors for source 1 in bits [11:4] and for source 2 in bits [20:13]. Routed lane i takes fetched lane sel[2i+1:2i], with 0=x, 1=y, 2=z, 3=w. Lane x occupies vector bits [23:0] and lane w occupies bits [95:72].
- R2: Entry bit 12 (source 1) and bit 21 (source 2) invert bit 23, the sign bit, of all four routed lanes of that source. The other 23 bits of each lane pass unchanged.
- R3: With the offset select at 0 or 3, the source 1 read index is the raw index. Select 1 adds areg0_i and select 2 adds areg1_i, both signed, with the sum wrapping modulo 128. The source 2 read index always equals its raw index.
- R4: An effective source index 0x00–0x0F reads the input bank (type 3'b001), 0x10–0x1F reads the temporary bank (type 3'b010), and 0x20–0x7F reads the uniform bank (type 3'b100). The local index is the effective index minus the bank base.
- R5: A destination index below 0x08 gives an output-bank write to register idx. An index from 0x10 to 0x1F gives a temporary write to register idx−0x10. An index from 0x08 to 0x0F gives no write.
- R6: The lane write mask is entry bits [3:0], where bit i enables lane i. It is forced to 0 whenever no write is issued.
- R7: A write to the pattern table updates one entry at the clock edge. An instruction that looks up the same entry in that cycle uses the old contents, and the next instruction uses the new contents.
- R8: valid_o equals instr_valid_i of the previous cycle. While valid_o is low, both write flags and the mask are 0.
- R9: After reset, valid_o, the operands, the write flags, the register and the mask are 0, and every pattern entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pat_we_i | input | 1 | Pattern table write strobe |
| pat_addr_i | input | 4 | Pattern entry to write |
| pat_wdata_i | input | 22 | Pattern entry contents |
| instr_valid_i | input | 1 | Instruction issued this cycle |
| desc_id_i | input | 4 | Pattern entry used by the instruction |
| src1_sel_i | input | 7 | Raw source 1 index |
| src2_sel_i | input | 7 | Raw source 2 index |
| areg_sel_i | input | 2 | Offset select for source 1 |
| areg0_i | input | 8 | Address register 0, signed |
| areg1_i | input | 8 | Address register 1, signed |
| dst_sel_i | input | 5 | Raw destination index |
| src1_idx_o | output | 7 | Effective source 1 read index |
| src1_type_o | output | 3 | Source 1 bank, one-hot |
| src1_local_o | output | 7 | Source 1 index within its bank |
| src2_idx_o | output | 7 | Source 2 read index |
| src2_type_o | output | 3 | Source 2 bank, one-hot |
| src2_local_o | output | 7 | Source 2 index within its bank |
| src1_data_i | input | 96 | Fetched source 1 vector |
| src2_data_i | input | 96 | Fetched source 2 vector |
| valid_o | output | 1 | Routed results valid |
| op1_o | output | 96 | Routed source 1 |
| op2_o | output | 96 | Routed source 2 |
| wr_out_o | output | 1 | Write goes to output bank |
| wr_tmp_o | output | 1 | Write goes to temporary bank |
| wr_reg_o | output | 4 | Destination register within its bank |
| wr_mask_o | output | 4 | Lane write enables |

## Verification
A table write and an instruction lookup can land in the same cycle, and they may target the same entry. The sweep lets writes collide with lookups, some to the entry in use and some to other entries. A directed pair writes the entry an instruction is reading and then reuses that entry on the next instruction. The bench keeps its own copy of the table and applies each write only after computing the expected result of the colliding instruction. The first instruction must therefore show the old lane order, sign and mask, and the second must show the new ones.

// File: rtl/vop_pkg.sv
package vop_pkg;
  localparam int COMP_W    = 24;
  localparam int N_COMP    = 4;
  localparam int SEL_W     = 2;
  localparam int VEC_W     = COMP_W * N_COMP;
  localparam int SRC_IW    = 7;
  localparam int DST_IW    = 5;
  localparam int AREG_W    = 8;
  localparam int PAT_AW    = 4;
  localparam int PAT_DEPTH = 1 << PAT_AW;
  localparam int SWZ_W     = N_COMP * SEL_W;
  localparam int PAT_W     = N_COMP + 2 * (SWZ_W + 1);
  localparam int REG_W     = 4;

  localparam logic [SRC_IW-1:0] TMP_BASE = SRC_IW'(16);
  localparam logic [SRC_IW-1:0] UNI_BASE = SRC_IW'(32);
  localparam logic [SRC_IW-1:0] UNI_CNT  = SRC_IW'(96);
  localparam logic [DST_IW-1:0] OUT_LIM  = DST_IW'(8);

  typedef struct packed {
    logic             neg2;
    logic [SWZ_W-1:0] sel2;
    logic             neg1;
    logic [SWZ_W-1:0] sel1;
    logic [N_COMP-1:0] mask;
  } pat_t;

  typedef enum logic [2:0] {
    SRC_IN  = 3'b001,
    SRC_TMP = 3'b010,
    SRC_UNI = 3'b100
  } src_kind_e;
endpackage

// File: rtl/vop_pattern_table.sv
module vop_pattern_table
  import vop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAT_AW-1:0] waddr_i,
  input  pat_t              wdata_i,
  input  logic [PAT_AW-1:0] raddr_i,
  output pat_t              rdata_o
);
  pat_t ent_q [PAT_DEPTH];

  for (genvar e = 0; e < PAT_DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q[e] <= '0;
      else if (we_i && waddr_i == PAT_AW'(e))       ent_q[e] <= wdata_i;
    end
  end

  // Read sees pre-write contents on a same-cycle collision
  assign rdata_o = ent_q[raddr_i];

  p_write_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ent_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/vop_src_index.sv
module vop_src_index
  import vop_pkg::*;
(
  input  logic [SRC_IW-1:0]        base_i,
  input  logic signed [AREG_W-1:0] ofs_i,
  output logic [SRC_IW-1:0]        eff_o,
  output src_kind_e                kind_o,
  output logic [SRC_IW-1:0]        local_o
);
  logic [SRC_IW-1:0] ofs_t;
  assign ofs_t = ofs_i[SRC_IW-1:0];
  assign eff_o = base_i + ofs_t;

  always_comb begin
    if (eff_o < TMP_BASE) begin
      kind_o  = SRC_IN;
      local_o = eff_o;
    end else if (eff_o < UNI_BASE) begin
      kind_o  = SRC_TMP;
      local_o = eff_o - TMP_BASE;
    end else begin
      kind_o  = SRC_UNI;
      local_o = eff_o - UNI_BASE;
    end
  end
endmodule

// File: rtl/vop_swizzle.sv
module vop_swizzle
  import vop_pkg::*;
(
  input  logic [VEC_W-1:0] vec_i,
  input  logic [SWZ_W-1:0] sel_i,
  input  logic             neg_i,
  output logic [VEC_W-1:0] vec_o
);
  logic [COMP_W-1:0] lane [N_COMP];

  for (genvar g = 0; g < N_COMP; g++) begin : g_lane
    assign lane[g] = vec_i[g*COMP_W +: COMP_W];
  end

  for (genvar g = 0; g < N_COMP; g++) begin : g_out
    logic [COMP_W-1:0] pick;
    assign pick = lane[sel_i[g*SEL_W +: SEL_W]];
    // sign-bit flip only; exponent and mantissa untouched
    assign vec_o[g*COMP_W +: COMP_W] = {pick[COMP_W-1] ^ neg_i, pick[COMP_W-2:0]};
  end
endmodule

// File: rtl/vop_dst_decode.sv
module vop_dst_decode
  import vop_pkg::*;
(
  input  logic [DST_IW-1:0] dst_i,
  output logic              out_en_o,
  output logic              tmp_en_o,
  output logic [REG_W-1:0]  reg_o
);
  assign out_en_o = dst_i < OUT_LIM;
  assign tmp_en_o = dst_i[DST_IW-1];
  assign reg_o    = dst_i[REG_W-1:0];
endmodule

// File: rtl/vec_operand_router.sv
module vec_operand_router
  import vop_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pat_we_i,
  input  logic [3:0]          pat_addr_i,
  input  logic [21:0]         pat_wdata_i,
  input  logic                instr_valid_i,
  input  logic [3:0]          desc_id_i,
  input  logic [6:0]          src1_sel_i,
  input  logic [6:0]          src2_sel_i,
  input  logic [1:0]          areg_sel_i,
  input  logic [7:0]          areg0_i,
  input  logic [7:0]          areg1_i,
  input  logic [4:0]          dst_sel_i,
  output logic [6:0]          src1_idx_o,
  output logic [2:0]          src1_type_o,
  output logic [6:0]          src1_local_o,
  output logic [6:0]          src2_idx_o,
  output logic [2:0]          src2_type_o,
  output logic [6:0]          src2_local_o,
  input  logic [95:0]         src1_data_i,
  input  logic [95:0]         src2_data_i,
  output logic                valid_o,
  output logic [95:0]         op1_o,
  output logic [95:0]         op2_o,
  output logic                wr_out_o,
  output logic                wr_tmp_o,
  output logic [3:0]          wr_reg_o,
  output logic [3:0]          wr_mask_o
);
  pat_t pat;
  vop_pattern_table u_tab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pat_we_i),
    .waddr_i (pat_addr_i),
    .wdata_i (pat_t'(pat_wdata_i)),
    .raddr_i (desc_id_i),
    .rdata_o (pat)
  );

  logic signed [AREG_W-1:0] ofs1;
  always_comb begin
    unique case (areg_sel_i)
      2'd1:    ofs1 = areg0_i;
      2'd2:    ofs1 = areg1_i;
      default: ofs1 = '0;
    endcase
  end

  logic [SRC_IW-1:0]        base_a [2];
  logic signed [AREG_W-1:0] ofs_a  [2];
  logic [SRC_IW-1:0]        eff_a  [2];
  src_kind_e                kind_a [2];
  logic [SRC_IW-1:0]        loc_a  [2];
  logic [VEC_W-1:0]         raw_a  [2];
  logic [VEC_W-1:0]         rt_a   [2];
  logic [SWZ_W-1:0]         sel_a  [2];
  logic                     neg_a  [2];

  assign base_a[0] = src1_sel_i;
  assign base_a[1] = src2_sel_i;
  assign ofs_a[0]  = ofs1;
  assign ofs_a[1]  = '0;
  assign raw_a[0]  = src1_data_i;
  assign raw_a[1]  = src2_data_i;
  assign sel_a[0]  = pat.sel1;
  assign sel_a[1]  = pat.sel2;
  assign neg_a[0]  = pat.neg1;
  assign neg_a[1]  = pat.neg2;

  for (genvar s = 0; s < 2; s++) begin : g_src
    vop_src_index u_idx (
      .base_i  (base_a[s]),
      .ofs_i   (ofs_a[s]),
      .eff_o   (eff_a[s]),
      .kind_o  (kind_a[s]),
      .local_o (loc_a[s])
    );
    vop_swizzle u_swz (
      .vec_i (raw_a[s]),
      .sel_i (sel_a[s]),
      .neg_i (neg_a[s]),
      .vec_o (rt_a[s])
    );
  end

  assign src1_idx_o   = eff_a[0];
  assign src1_type_o  = kind_a[0];
  assign src1_local_o = loc_a[0];
  assign src2_idx_o   = eff_a[1];
  assign src2_type_o  = kind_a[1];
  assign src2_local_o = loc_a[1];

  logic             d_out, d_tmp;
  logic [REG_W-1:0] d_reg;
  vop_dst_decode u_dst (
    .dst_i    (dst_sel_i),
    .out_en_o (d_out),
    .tmp_en_o (d_tmp),
    .reg_o    (d_reg)
  );

  logic wr_any;
  assign wr_any = instr_valid_i & (d_out | d_tmp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      op1_o     <= '0;
      op2_o     <= '0;
      wr_out_o  <= 1'b0;
      wr_tmp_o  <= 1'b0;
      wr_reg_o  <= '0;
      wr_mask_o <= '0;
    end else begin
      valid_o   <= instr_valid_i;
      wr_out_o  <= instr_valid_i & d_out;
      wr_tmp_o  <= instr_valid_i & d_tmp;
      wr_reg_o  <= wr_any ? d_reg : '0;
      wr_mask_o <= wr_any ? pat.mask : '0;
      if (instr_valid_i) begin
        op1_o <= rt_a[0];
        op2_o <= rt_a[1];
      end
    end
  end

  // assertion support: marks the first edge after reset release
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> valid_o == $past(instr_valid_i));
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!wr_out_o && !wr_tmp_o && wr_mask_o == '0));
  p_one_bank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_out_o, wr_tmp_o}));
  p_mask_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask_o != '0) |-> (wr_out_o || wr_tmp_o));
  p_src2_flat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i |-> src2_idx_o == src2_sel_i);
  p_uni_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src1_type_o == SRC_UNI) |-> src1_local_o < UNI_CNT);
endmodule

// File: tb/tb_vec_operand_router.sv
`timescale 1ns/1ps
module tb_vec_operand_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        pat_we = 0;
  logic [3:0]  pat_addr = 0;
  logic [21:0] pat_wdata = 0;
  logic        iv = 0;
  logic [3:0]  desc = 0;
  logic [6:0]  s1 = 0, s2 = 0;
  logic [1:0]  asel = 0;
  logic [7:0]  a0 = 0, a1 = 0;
  logic [4:0]  dst = 0;
  logic [6:0]  s1_idx, s1_loc, s2_idx, s2_loc;
  logic [2:0]  s1_ty, s2_ty;
  logic [95:0] d1, d2, op1, op2;
  logic        vld, wo, wt;
  logic [3:0]  wreg, wmask;

  vec_operand_router dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pat_we_i(pat_we), .pat_addr_i(pat_addr), .pat_wdata_i(pat_wdata),
    .instr_valid_i(iv), .desc_id_i(desc), .src1_sel_i(s1), .src2_sel_i(s2),
    .areg_sel_i(asel), .areg0_i(a0), .areg1_i(a1), .dst_sel_i(dst),
    .src1_idx_o(s1_idx), .src1_type_o(s1_ty), .src1_local_o(s1_loc),
    .src2_idx_o(s2_idx), .src2_type_o(s2_ty), .src2_local_o(s2_loc),
    .src1_data_i(d1), .src2_data_i(d2),
    .valid_o(vld), .op1_o(op1), .op2_o(op2),
    .wr_out_o(wo), .wr_tmp_o(wt), .wr_reg_o(wreg), .wr_mask_o(wmask)
  );

  function automatic logic [23:0] rf_comp(logic [6:0] idx, int c);
    return {idx[0], idx, 2'(c), 14'(int'(idx) * 37 + c * 5)};
  endfunction
  function automatic logic [95:0] rf_vec(logic [6:0] idx);
    logic [95:0] v;
    for (int c = 0; c < 4; c++) v[c*24 +: 24] = rf_comp(idx, c);
    return v;
  endfunction

  always_comb d1 = rf_vec(s1_idx);
  always_comb d2 = rf_vec(s2_idx);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [21:0] pat_m [16];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  logic        pend = 0;
  logic [95:0] e_op1, e_op2;
  logic        e_wo, e_wt;
  logic [3:0]  e_reg, e_mask;

  function automatic logic [95:0] route(logic [6:0] idx, logic [7:0] sel, logic neg);
    logic [95:0] v;
    for (int i = 0; i < 4; i++)
      v[i*24 +: 24] = rf_comp(idx, int'(sel[i*2 +: 2])) ^ {neg, 23'b0};
    return v;
  endfunction

  function automatic logic [2:0] kind(logic [6:0] e);
    return (e < 7'd16) ? 3'b001 : (e < 7'd32) ? 3'b010 : 3'b100;
  endfunction
  function automatic logic [6:0] loc(logic [6:0] e);
    return (e < 7'd16) ? e : (e < 7'd32) ? e - 7'd16 : e - 7'd32;
  endfunction

  task automatic step(input logic v, input logic [3:0] dsc, input logic [6:0] x1, input logic [6:0] x2,
                      input logic [1:0] as, input logic [7:0] r0, input logic [7:0] r1, input logic [4:0] d,
                      input logic we, input logic [3:0] wa, input logic [21:0] wd);
    logic [6:0]  eff;
    logic [21:0] p;
    @(negedge clk);
    if (pend) begin
      chk("R8 valid", 96'(vld), 96'(1));
      chk("R1/R2 op1", op1, e_op1);
      chk("R1/R2 op2", op2, e_op2);
      chk("R5 wr_out", 96'(wo), 96'(e_wo));
      chk("R5 wr_tmp", 96'(wt), 96'(e_wt));
      chk("R5 wr_reg", 96'(wreg), 96'(e_reg));
      chk("R6 mask", 96'(wmask), 96'(e_mask));
    end else begin
      chk("R8 idle", {92'(vld), wo, wt, wmask != 4'd0}, 96'(0));
    end
    iv = v; desc = dsc; s1 = x1; s2 = x2; asel = as; a0 = r0; a1 = r1; dst = d;
    pat_we = we; pat_addr = wa; pat_wdata = wd;
    #1;
    if (v) begin
      eff = x1 + ((as == 2'd1) ? r0[6:0] : (as == 2'd2) ? r1[6:0] : 7'd0);
      chk("R3 src1 idx", 96'(s1_idx), 96'(eff));
      chk("R3 src2 idx", 96'(s2_idx), 96'(x2));
      chk("R4 src1 type", {89'(s1_ty), s1_loc}, {89'(kind(eff)), loc(eff)});
      chk("R4 src2 type", {89'(s2_ty), s2_loc}, {89'(kind(x2)), loc(x2)});
      p = pat_m[dsc];
      e_op1 = route(eff, p[11:4], p[12]);
      e_op2 = route(x2, p[20:13], p[21]);
      e_wo = d < 5'd8;
      e_wt = d >= 5'd16;
      e_reg = (e_wo || e_wt) ? d[3:0] : 4'd0;
      e_mask = (e_wo || e_wt) ? p[3:0] : 4'd0;
    end
    pend = v;
    if (we) pat_m[wa] = wd;
  endtask

  initial begin
    logic [21:0] newp;
    for (int e = 0; e < 16; e++) pat_m[e] = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset", {vld, wo, wt, wreg, wmask, 84'd0}, 96'd0);
    chk("R9 op1", op1, 96'd0);
    chk("R9 op2", op2, 96'd0);
    rst_n = 1'b1;
    // R9: table reset to zero -> all lanes pick x, no flip, empty mask
    step(1, 4'd9, 7'h21, 7'h05, 2'd0, 8'd0, 8'd0, 5'd3, 0, 4'd0, 22'd0);
    for (int e = 0; e < 16; e++)
      step(0, 4'd0, 7'd0, 7'd0, 2'd0, 8'd0, 8'd0, 5'd0, 1, 4'(e), 22'(rnd()));
    for (int n = 0; n < 1600; n++) begin
      logic [31:0] r, q;
      r = rnd(); q = rnd();
      step(n % 5 != 4, 4'(n % 16), r[6:0], r[13:7], 2'(n % 4), r[23:16], q[7:0], 5'(n % 32),
           n % 7 == 3, (n % 14 == 3) ? 4'(n % 16) : q[11:8], 22'(rnd()));
    end
    // R7: collision on the entry in use, then reuse
    newp = 22'h2A_5A5F;
    step(1, 4'd5, 7'h11, 7'h40, 2'd0, 8'd0, 8'd0, 5'd16, 1, 4'd5, newp);
    step(1, 4'd5, 7'h11, 7'h40, 2'd0, 8'd0, 8'd0, 5'd16, 0, 4'd0, 22'd0);
    // R3 wrap and negative offset, R4/R5 boundaries
    step(1, 4'd5, 7'h7F, 7'h1F, 2'd1, 8'd1, 8'd0, 5'd7, 0, 4'd0, 22'd0);
    step(1, 4'd5, 7'h10, 7'h20, 2'd2, 8'd0, 8'hFF, 5'd8, 0, 4'd0, 22'd0);
    step(1, 4'd5, 7'h0F, 7'h7F, 2'd3, 8'd5, 8'd9, 5'd15, 0, 4'd0, 22'd0);
    step(1, 4'd5, 7'h1F, 7'h10, 2'd1, 8'd1, 8'd0, 5'd31, 0, 4'd0, 22'd0);
    step(0, 4'd0, 7'd0, 7'd0, 2'd0, 8'd0, 8'd0, 5'd0, 0, 4'd0, 22'd0);
    step(0, 4'd0, 7'd0, 7'd0, 2'd0, 8'd0, 8'd0, 5'd0, 0, 4'd0, 22'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule